// File: doc/BRIEF.md
# Multithreaded Commit Squash Controller

This block holds the commit-side status of every hardware thread in a small multithreaded out-of-order core and decides which squash requests take effect. Three sources can ask for a squash: the execute stage (a mispredicted branch or a replayed instruction, carrying a sequence number), a per-thread trap timer that expires a fixed number of cycles after a trap is raised, and an external write to the thread's architectural context. Accepted squashes are broadcast to the earlier pipeline stages one cycle later. The broadcast carries the sequence number below which work survives, the restart PC and a mispredict flag.

The block also tracks the youngest sequence number the reorder buffer holds for each thread and counts how many threads are squashing. It raises an activity output whenever any thread has squash or trap work outstanding. The reorder buffer is seen only through three per-thread inputs: a flag that says its squash walk is finished, an empty flag and the sequence number at its head. Sequence numbers are 16-bit unsigned values and are compared without wraparound.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After reset every thread is Idle, the squashing count is 0, no broadcast is raised, and both `allSquashing` and `stageActive` are low. Thread states are encoded Idle=0, Running=1, Squashing=2, TrapPending=3, FetchTrapPending=4.
- R2: An instruction insert (`insValid`) on a thread that is not Squashing sets that thread's youngest sequence number to `insSeq` and moves an Idle thread to Running. An insert on a Squashing thread is ignored.
- R3: An execute squash is accepted only if the thread is not in TrapPending and `exSqSeq` is less than or equal to the thread's youngest sequence number. If accepted, `bcSquash` for that thread pulses for one cycle after the sampling edge and the thread enters Squashing.
- R4: For an accepted execute squash, the effective number is `exSqSeq` minus 1 when `exSqInclude` is set and `exSqSeq` otherwise. This number becomes the youngest sequence number and `bcDoneSeq`. `bcNextPc` and `bcMispredict` copy the execute inputs.
- R5: A Squashing thread whose `robDoneSquash` is high at an edge returns to Running. `squashCount` always equals the number of threads in Squashing.
- R6: `allSquashing` is high exactly when every thread is Squashing. While it is high, no insert is accepted.
- R7: `trapRaise` on a thread that is neither TrapPending nor Squashing moves it to TrapPending. With trap latency L, the full-thread squash broadcast appears after edge L+1, counting the raising edge as edge 0.
- R8: A full-thread squash (from a trap or a context write) sets `bcDoneSeq` to `robHeadSeq` minus 1, or to 0 when `robEmpty` is high. It also sets the youngest sequence number to 0, forces `bcMispredict` low and takes `bcNextPc` from `commitPc`.
- R9: `ctxSquash` causes a full-thread squash at the next edge, except on a thread in TrapPending, where it is ignored. If a trap squash fires in the same cycle, only the trap squash is performed.
- R10: `fetchFault` moves an Idle or Running thread to FetchTrapPending. `fetchFaultClear` returns a FetchTrapPending thread to Running.
- R11: `stageActive` is high whenever any thread is Squashing, TrapPending or FetchTrapPending. `bcRobSquashing` shows, per thread, that the thread is Squashing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| exSqValid | input | NT | Execute-stage squash request per thread |
| exSqSeq | input | NT x SEQ_W | Sequence number of the squashing instruction |
| exSqInclude | input | NT | Squash the requesting instruction too |
| exSqMispredict | input | NT | Request comes from a branch mispredict |
| exSqNextPc | input | NT x PC_W | Restart PC of the execute squash |
| trapRaise | input | NT | Start of a trap on the thread |
| ctxSquash | input | NT | External context write needs a full squash |
| fetchFault | input | NT | Fault reported by fetch |
| fetchFaultClear | input | NT | Fetch withdrew its fault |
| insValid | input | NT | Instruction inserted into the reorder buffer |
| insSeq | input | NT x SEQ_W | Sequence number of the inserted instruction |
| robDoneSquash | input | NT | Reorder buffer finished its squash walk |
| robEmpty | input | NT | Reorder buffer holds nothing for the thread |
| robHeadSeq | input | NT x SEQ_W | Sequence number at the reorder buffer head |
| commitPc | input | NT x PC_W | Current commit PC of the thread |
| bcSquash | output | NT | One-cycle squash broadcast |
| bcRobSquashing | output | NT | Thread is squashing |
| bcDoneSeq | output | NT x SEQ_W | Youngest surviving sequence number |
| bcNextPc | output | NT x PC_W | Restart PC |
| bcMispredict | output | NT | Broadcast caused by a mispredict |
| threadState | output | NT x 3 | Per-thread state code |
| squashCount | output | clog2(NT+1) | Number of squashing threads |
| allSquashing | output | 1 | Every thread is squashing |
| stageActive | output | 1 | Squash or trap work outstanding |

## Verification
Every input is sampled at one rising edge and the broadcast, state and count show its effect straight after that edge. The bench therefore drives a stimulus after a falling edge and checks the outputs at the next falling edge. The exception is the trap path, which is due L+1 edges after the raising edge. There the bench checks the absence of a broadcast after each of the L intermediate edges and its presence after the last one. Acceptance or rejection of a later execute squash is the port-level evidence of the youngest sequence number, so inserts that must be ignored are checked through that.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
  typedef enum logic [2:0] {
    TS_IDLE  = 3'd0,
    TS_RUN   = 3'd1,
    TS_ROBSQ = 3'd2,
    TS_TRAP  = 3'd3,
    TS_FTRAP = 3'd4
  } thrState_e;

  // per-thread strobes from control to datapath
  typedef struct packed {
    logic fullSq;  // whole-thread squash (trap or context write)
    logic exSq;    // accepted execute squash
    logic insert;  // accepted instruction insert
    logic enter;   // thread enters squashing
    logic leave;   // thread leaves squashing
  } sqStrobe_t;
endpackage

// File: rtl/sqc_ctrl.sv
module sqc_ctrl
  import sqc_pkg::*;
#(
  parameter int NT       = 2,
  parameter int TRAP_LAT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NT-1:0]          exSqValid,
  input  logic [NT-1:0]          trapRaise,
  input  logic [NT-1:0]          ctxSquash,
  input  logic [NT-1:0]          fetchFault,
  input  logic [NT-1:0]          fetchFaultClear,
  input  logic [NT-1:0]          insValid,
  input  logic [NT-1:0]          robDoneSquash,
  input  logic [NT-1:0]          youngOk,
  input  logic [NT-1:0]          seqZero,
  input  logic                   allSquashing,
  output sqStrobe_t [NT-1:0]     strobe,
  output logic [NT-1:0][2:0]     stateOut
);
  localparam int LAT_W = $clog2(TRAP_LAT + 1);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    thrState_e        stQ, stD, afterDone;
    logic [LAT_W-1:0] tmrQ, tmrD;
    logic             fireQ;
    logic             fullSq, exAcc, insAcc, trapGo;

    always_comb begin
      afterDone = (stQ == TS_ROBSQ && robDoneSquash[t]) ? TS_RUN : stQ;
      // context write ignored while a trap is pending or firing
      fullSq = fireQ || (ctxSquash[t] && stQ != TS_TRAP);
      exAcc  = exSqValid[t] && (stQ != TS_TRAP || fireQ) &&
               (fullSq ? seqZero[t] : youngOk[t]);
      insAcc = insValid[t] && !allSquashing && stQ != TS_ROBSQ &&
               !fullSq && !exAcc;
      trapGo = trapRaise[t] && !fullSq && !exAcc &&
               stQ != TS_TRAP && stQ != TS_ROBSQ;

      if (fullSq || exAcc)
        stD = TS_ROBSQ;
      else if (trapGo)
        stD = TS_TRAP;
      else if (fetchFault[t] && (afterDone == TS_RUN || afterDone == TS_IDLE))
        stD = TS_FTRAP;
      else if (fetchFaultClear[t] && stQ == TS_FTRAP)
        stD = TS_RUN;
      else if (insAcc && stQ == TS_IDLE)
        stD = TS_RUN;
      else
        stD = afterDone;

      if (trapGo)
        tmrD = LAT_W'(TRAP_LAT);
      else if (tmrQ != '0)
        tmrD = tmrQ - LAT_W'(1);
      else
        tmrD = tmrQ;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stQ   <= TS_IDLE;
        tmrQ  <= '0;
        fireQ <= 1'b0;
      end else begin
        stQ   <= stD;
        tmrQ  <= tmrD;
        fireQ <= (tmrQ == LAT_W'(1));
      end
    end

    assign strobe[t].fullSq = fullSq;
    assign strobe[t].exSq   = exAcc;
    assign strobe[t].insert = insAcc;
    assign strobe[t].enter  = (stD == TS_ROBSQ) && (stQ != TS_ROBSQ);
    assign strobe[t].leave  = (stQ == TS_ROBSQ) && (stD != TS_ROBSQ);
    assign stateOut[t]      = stQ;
  end
endmodule

// File: rtl/sqc_datapath.sv
module sqc_datapath
  import sqc_pkg::*;
#(
  parameter int NT    = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  localparam int CNT_W = $clog2(NT + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sqStrobe_t [NT-1:0]         strobe,
  input  logic [NT-1:0][SEQ_W-1:0]   exSqSeq,
  input  logic [NT-1:0]              exSqInclude,
  input  logic [NT-1:0]              exSqMispredict,
  input  logic [NT-1:0][PC_W-1:0]    exSqNextPc,
  input  logic [NT-1:0][SEQ_W-1:0]   insSeq,
  input  logic [NT-1:0]              robEmpty,
  input  logic [NT-1:0][SEQ_W-1:0]   robHeadSeq,
  input  logic [NT-1:0][PC_W-1:0]    commitPc,
  output logic [NT-1:0]              youngOk,
  output logic [NT-1:0]              seqZero,
  output logic [NT-1:0]              bcSquash,
  output logic [NT-1:0][SEQ_W-1:0]   bcDoneSeq,
  output logic [NT-1:0][PC_W-1:0]    bcNextPc,
  output logic [NT-1:0]              bcMispredict,
  output logic [CNT_W-1:0]           squashCount,
  output logic                       allSquashing
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [SEQ_W-1:0] youngQ, effSeq, fullSeq;

    assign effSeq  = exSqSeq[t] - SEQ_W'(exSqInclude[t]);
    assign fullSeq = robEmpty[t] ? '0 : robHeadSeq[t] - SEQ_W'(1);
    assign youngOk[t] = exSqSeq[t] <= youngQ;
    assign seqZero[t] = exSqSeq[t] == '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        youngQ          <= '0;
        bcSquash[t]     <= 1'b0;
        bcDoneSeq[t]    <= '0;
        bcNextPc[t]     <= '0;
        bcMispredict[t] <= 1'b0;
      end else begin
        bcSquash[t] <= strobe[t].fullSq | strobe[t].exSq;
        if (strobe[t].exSq) begin
          youngQ          <= effSeq;
          bcDoneSeq[t]    <= effSeq;
          bcNextPc[t]     <= exSqNextPc[t];
          bcMispredict[t] <= exSqMispredict[t];
        end else if (strobe[t].fullSq) begin
          youngQ          <= '0;
          bcDoneSeq[t]    <= fullSeq;
          bcNextPc[t]     <= commitPc[t];
          bcMispredict[t] <= 1'b0;
        end else if (strobe[t].insert) begin
          youngQ <= insSeq[t];
        end
      end
    end
  end

  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    cntD = cntQ;
    for (int t = 0; t < NT; t++) begin
      if (strobe[t].enter) cntD = cntD + CNT_W'(1);
      if (strobe[t].leave) cntD = cntD - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else       cntQ <= cntD;
  end

  assign squashCount  = cntQ;
  assign allSquashing = (cntQ == CNT_W'(NT));
endmodule

// File: rtl/commit_squash_ctrl.sv
module commit_squash_ctrl
  import sqc_pkg::*;
#(
  parameter int NT       = 2,
  parameter int SEQ_W    = 16,
  parameter int PC_W     = 32,
  parameter int TRAP_LAT = 4,
  localparam int CNT_W   = $clog2(NT + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NT-1:0]              exSqValid,
  input  logic [NT-1:0][SEQ_W-1:0]   exSqSeq,
  input  logic [NT-1:0]              exSqInclude,
  input  logic [NT-1:0]              exSqMispredict,
  input  logic [NT-1:0][PC_W-1:0]    exSqNextPc,
  input  logic [NT-1:0]              trapRaise,
  input  logic [NT-1:0]              ctxSquash,
  input  logic [NT-1:0]              fetchFault,
  input  logic [NT-1:0]              fetchFaultClear,
  input  logic [NT-1:0]              insValid,
  input  logic [NT-1:0][SEQ_W-1:0]   insSeq,
  input  logic [NT-1:0]              robDoneSquash,
  input  logic [NT-1:0]              robEmpty,
  input  logic [NT-1:0][SEQ_W-1:0]   robHeadSeq,
  input  logic [NT-1:0][PC_W-1:0]    commitPc,
  output logic [NT-1:0]              bcSquash,
  output logic [NT-1:0]              bcRobSquashing,
  output logic [NT-1:0][SEQ_W-1:0]   bcDoneSeq,
  output logic [NT-1:0][PC_W-1:0]    bcNextPc,
  output logic [NT-1:0]              bcMispredict,
  output logic [NT-1:0][2:0]         threadState,
  output logic [CNT_W-1:0]           squashCount,
  output logic                       allSquashing,
  output logic                       stageActive
);
  sqStrobe_t [NT-1:0] strobe;
  logic [NT-1:0]      youngOk, seqZero;
  logic [NT-1:0]      busy;

  sqc_ctrl #(.NT(NT), .TRAP_LAT(TRAP_LAT)) u_ctrl (
    .clk, .rstN, .exSqValid, .trapRaise, .ctxSquash, .fetchFault,
    .fetchFaultClear, .insValid, .robDoneSquash, .youngOk, .seqZero,
    .allSquashing, .strobe, .stateOut(threadState)
  );

  sqc_datapath #(.NT(NT), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_dp (
    .clk, .rstN, .strobe, .exSqSeq, .exSqInclude, .exSqMispredict,
    .exSqNextPc, .insSeq, .robEmpty, .robHeadSeq, .commitPc, .youngOk,
    .seqZero, .bcSquash, .bcDoneSeq, .bcNextPc, .bcMispredict,
    .squashCount, .allSquashing
  );

  for (genvar t = 0; t < NT; t++) begin : g_flag
    assign bcRobSquashing[t] = threadState[t] == TS_ROBSQ;
    assign busy[t] = threadState[t] == TS_ROBSQ || threadState[t] == TS_TRAP ||
                     threadState[t] == TS_FTRAP;
  end
  assign stageActive = |busy;
endmodule

// File: rtl/commit_squash_ctrl_checker.sv
module commit_squash_ctrl_checker #(
  parameter int NT = 2,
  parameter int CW = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [NT-1:0][2:0]  threadState,
  input logic [NT-1:0]       bcSquash,
  input logic [NT-1:0]       bcMispredict,
  input logic [NT-1:0]       exSqValid,
  input logic [NT-1:0]       robDoneSquash,
  input logic [CW-1:0]       squashCount,
  input logic                allSquashing
);
  int nSq;
  always_comb begin
    nSq = 0;
    for (int t = 0; t < NT; t++)
      if (threadState[t] == 3'd2) nSq++;
  end

  p_count_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    int'(squashCount) == nSq);

  p_all_squash_r6: assert property (@(posedge clk) disable iff (!rstN)
    allSquashing |-> nSq == NT);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    p_bcast_state_r3: assert property (@(posedge clk) disable iff (!rstN)
      bcSquash[t] |-> threadState[t] == 3'd2);

    p_full_no_mispred_r8: assert property (@(posedge clk) disable iff (!rstN)
      (bcSquash[t] && !$past(exSqValid[t])) |-> !bcMispredict[t]);

    p_exit_done_r5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(threadState[t]) == 3'd2 && threadState[t] == 3'd1) |->
        $past(robDoneSquash[t]));

    p_trap_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
      ($past(threadState[t]) == 3'd3 && threadState[t] != 3'd3) |-> bcSquash[t]);
  end
endmodule

bind commit_squash_ctrl commit_squash_ctrl_checker #(.NT(NT), .CW(CNT_W)) u_checker (
  .clk(clk), .rstN(rstN), .threadState(threadState), .bcSquash(bcSquash),
  .bcMispredict(bcMispredict), .exSqValid(exSqValid),
  .robDoneSquash(robDoneSquash), .squashCount(squashCount),
  .allSquashing(allSquashing)
);

// File: tb/commit_squash_ctrl_bench.sv
`timescale 1ns/1ps
module commit_squash_ctrl_bench;
  localparam int NT = 2, SEQ_W = 16, PC_W = 32, LAT = 4;
  localparam int CNT_W = $clog2(NT + 1);

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [NT-1:0]             exSqValid, exSqInclude, exSqMispredict;
  logic [NT-1:0][SEQ_W-1:0]  exSqSeq, insSeq, robHeadSeq;
  logic [NT-1:0][PC_W-1:0]   exSqNextPc, commitPc;
  logic [NT-1:0]             trapRaise, ctxSquash, fetchFault, fetchFaultClear;
  logic [NT-1:0]             insValid, robDoneSquash, robEmpty;
  logic [NT-1:0]             bcSquash, bcRobSquashing, bcMispredict;
  logic [NT-1:0][SEQ_W-1:0]  bcDoneSeq;
  logic [NT-1:0][PC_W-1:0]   bcNextPc;
  logic [NT-1:0][2:0]        threadState;
  logic [CNT_W-1:0]          squashCount;
  logic                      allSquashing, stageActive;

  commit_squash_ctrl #(.NT(NT), .SEQ_W(SEQ_W), .PC_W(PC_W), .TRAP_LAT(LAT)) u_commit_squash_ctrl (
    .clk, .rstN, .exSqValid, .exSqSeq, .exSqInclude, .exSqMispredict,
    .exSqNextPc, .trapRaise, .ctxSquash, .fetchFault, .fetchFaultClear,
    .insValid, .insSeq, .robDoneSquash, .robEmpty, .robHeadSeq, .commitPc,
    .bcSquash, .bcRobSquashing, .bcDoneSeq, .bcNextPc, .bcMispredict,
    .threadState, .squashCount, .allSquashing, .stageActive
  );

  int nChecks = 0, nFails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    exSqValid = '0; exSqInclude = '0; exSqMispredict = '0; exSqSeq = '0;
    exSqNextPc = '0; trapRaise = '0; ctxSquash = '0; fetchFault = '0;
    fetchFaultClear = '0; insValid = '0; insSeq = '0; robDoneSquash = '0;
  endtask

  // inputs are set before calling; sampled at the next posedge, checked after it
  task automatic step();
    @(negedge clk);
  endtask

  task automatic exReq(input int t, input int seq, input bit incl, input bit mis, input int pc);
    exSqValid[t] = 1'b1; exSqSeq[t] = SEQ_W'(seq); exSqInclude[t] = incl;
    exSqMispredict[t] = mis; exSqNextPc[t] = PC_W'(pc);
  endtask

  task automatic t_reset();
    chk("R1 state0", threadState[0], 0);
    chk("R1 state1", threadState[1], 0);
    chk("R1 count", squashCount, 0);
    chk("R1 bcast", bcSquash, 0);
    chk("R1 active", stageActive, 0);
    chk("R1 allsq", allSquashing, 0);
  endtask

  task automatic t_insert_exec();
    insValid = 2'b11; insSeq[0] = 100; insSeq[1] = 200; step(); clearIn();
    chk("R2 run0", threadState[0], 1);
    chk("R2 run1", threadState[1], 1);
    exReq(0, 90, 0, 1, 'h1000); step(); clearIn();
    chk("R3 bcast", bcSquash, 2'b01);
    chk("R4 done", bcDoneSeq[0], 90);
    chk("R4 mis", bcMispredict[0], 1);
    chk("R4 pc", bcNextPc[0], 'h1000);
    chk("R3 state", threadState[0], 2);
    chk("R5 count", squashCount, 1);
    chk("R11 active", stageActive, 1);
    chk("R11 robsq", bcRobSquashing, 2'b01);
    step();
    chk("R3 pulse one cycle", bcSquash, 0);
    // insert while squashing must not move the youngest number up
    insValid[0] = 1'b1; insSeq[0] = 120; step(); clearIn();
    exReq(0, 95, 0, 0, 'h1100); step(); clearIn();
    chk("R2 R3 younger squash rejected", bcSquash, 0);
    exReq(0, 80, 1, 0, 'h1200); step(); clearIn();
    chk("R3 older accepted", bcSquash, 2'b01);
    chk("R4 include", bcDoneSeq[0], 79);
    chk("R5 count stays", squashCount, 1);
  endtask

  task automatic t_done_all();
    robDoneSquash[0] = 1'b1; step(); clearIn();
    chk("R5 back running", threadState[0], 1);
    chk("R5 count dec", squashCount, 0);
    chk("R11 idle", stageActive, 0);
    exReq(0, 79, 0, 0, 'h1300); exReq(1, 150, 0, 0, 'h2000); step(); clearIn();
    chk("R6 count", squashCount, 2);
    chk("R6 all", allSquashing, 1);
    insValid[1] = 1'b1; insSeq[1] = 300; robDoneSquash[0] = 1'b1; step(); clearIn();
    chk("R6 drop one", allSquashing, 0);
    chk("R5 t0 run", threadState[0], 1);
    robDoneSquash[1] = 1'b1; step(); clearIn();
    exReq(1, 151, 0, 0, 'h2100); step(); clearIn();
    chk("R6 insert blocked", bcSquash, 0);
  endtask

  task automatic t_trap();
    robEmpty = '0; robHeadSeq[0] = 60; commitPc[0] = 'h3000;
    trapRaise[0] = 1'b1; step(); clearIn();
    chk("R7 pending", threadState[0], 3);
    chk("R11 trap active", stageActive, 1);
    for (int i = 1; i <= LAT; i++) begin
      if (i == 1) exReq(0, 10, 0, 1, 'h3100);
      if (i == 2) ctxSquash[0] = 1'b1;
      step(); clearIn();
      chk("R7 R3 R9 no early bcast", bcSquash, 0);
    end
    step();
    chk("R7 trap bcast", bcSquash, 2'b01);
    chk("R8 head-1", bcDoneSeq[0], 59);
    chk("R8 mis low", bcMispredict[0], 0);
    chk("R8 pc", bcNextPc[0], 'h3000);
    robDoneSquash[0] = 1'b1; step(); clearIn();
  endtask

  task automatic t_ctx();
    robEmpty[1] = 1'b1; commitPc[1] = 'h4000;
    ctxSquash[1] = 1'b1; step(); clearIn();
    chk("R9 ctx bcast", bcSquash, 2'b10);
    chk("R8 empty zero", bcDoneSeq[1], 0);
    chk("R8 ctx pc", bcNextPc[1], 'h4000);
    exReq(1, 5, 0, 0, 'h4100); step(); clearIn();
    chk("R8 youngest zero", bcSquash, 0);
    exReq(1, 0, 0, 0, 'h4200); step(); clearIn();
    chk("R8 seq0 ok", bcSquash, 2'b10);
    robDoneSquash[1] = 1'b1; step(); clearIn();
    // trap and context write in the same cycle
    trapRaise[1] = 1'b1; step(); clearIn();
    for (int i = 1; i <= LAT; i++) step();
    ctxSquash[1] = 1'b1; step(); clearIn();
    chk("R9 trap wins", bcSquash, 2'b10);
    step();
    chk("R9 ctx dropped", bcSquash, 0);
    chk("R9 count", squashCount, 1);
    robDoneSquash[1] = 1'b1; step(); clearIn();
  endtask

  task automatic t_fetch();
    fetchFault[1] = 1'b1; step(); clearIn();
    chk("R10 ftrap", threadState[1], 4);
    chk("R11 ftrap active", stageActive, 1);
    fetchFaultClear[1] = 1'b1; step(); clearIn();
    chk("R10 cleared", threadState[1], 1);
    chk("R11 quiet", stageActive, 0);
  endtask

  bit finished = 1'b0;

  initial begin
    clearIn(); robEmpty = '1; robHeadSeq = '0; commitPc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    t_reset();
    t_insert_exec();
    t_done_all();
    t_trap();
    t_ctx();
    t_fetch();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule